// File: doc/BRIEF.md
# Negacyclic Polynomial Multiplier over a Small Prime Field

This block computes the product of two polynomials of degree below N. Coefficients lie in the integers modulo a small prime P, and the product is reduced by x^N + 1. Because of that reduction, any term that would reach x^N or beyond comes back at the low end with its sign flipped. The defaults are N = 8, P = 17 and PSI = 3. Here PSI is a primitive 2N-th root of unity modulo P, and one exists because P leaves remainder 1 when divided by 2N.

Software or a neighbouring engine first writes both operands one coefficient per cycle. It then pulses `start`. The block weights each operand by powers of PSI and transforms both operands at the same time, using two butterfly units with one multiplier each. It multiplies the two spectra point by point. Both butterfly units then share the single inverse transform, so that pass takes half as many cycles as the forward pass. A final weighting by PSI to the power −i, with N⁻¹ mod P folded in, produces the product. The result leaves the block on a serial port, one coefficient per cycle, and a one-cycle `done` pulse follows it.

Top module: `ntt_negamul`

## Requirements
- R1: Each output coefficient c[k] equals the sum, modulo 17, of a[i]·b[j] over i+j = k minus the sum of a[i]·b[j] over i+j = k+8. Every value is in the range 0 to 16.
- R2: While `busy` is low, a cycle with `ld_we` = 1 stores `ld_data` as coefficient number `ld_addr` of operand a when `ld_sel` = 0, and of operand b when `ld_sel` = 1. Loaded values must be below 17.
- R3: `start` sampled high while `busy` is low launches a computation, and `busy` is high from the next cycle.
- R4: `out_valid` first rises after the 35th rising edge, counting the edge that samples `start` as the first. It then stays high for 8 consecutive cycles, with `out_idx` counting 0 to 7 and `out_data` carrying that coefficient.
- R5: `done` is high for exactly one cycle, the cycle immediately after the one in which `out_idx` = 7 was presented.
- R6: `start` is ignored while `busy` is high. The running computation neither restarts nor changes its timing or result.
- R7: `ld_we` is ignored while `busy` is high. The running computation's result is unchanged.
- R8: Multiplying c1·x^i by c2·x^j with i+j ≥ 8 yields (17 − c1·c2 mod 17) mod 17 at index i+j−8 and 0 elsewhere.
- R9: After reset, `busy`, `done` and `out_valid` are low.
- R10: A `start` presented in the cycle where `done` is high is accepted, and the new run follows the same timing as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch request, honoured only while idle |
| ld_we | input | 1 | Coefficient write strobe |
| ld_sel | input | 1 | Operand select: 0 = a, 1 = b |
| ld_addr | input | 3 | Coefficient index being written |
| ld_data | input | 5 | Coefficient value, below 17 |
| busy | output | 1 | High from launch until the last output cycle |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | 1 | Result coefficient valid |
| out_idx | output | 3 | Index of the coefficient on `out_data` |
| out_data | output | 5 | Result coefficient |

## Verification
Two events can fall in the same cycle. The first pair is the completion pulse and a fresh launch. The bench raises `start` in exactly the cycle where `done` is high, then judges acceptance by `busy` in the next cycle and by the 35-edge latency to the first output. The second pair is an external write arriving while the butterflies are rewriting the coefficient store. The bench strobes `ld_we` in the middle of the transform and then compares every result coefficient against a schoolbook negacyclic product worked out in the bench. The same comparison covers an exhaustive sweep over all 64 monomial pairs, which exercises every wrap-around sign, and a set of random operand pairs.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_FWD,
    PH_PMUL,
    PH_INV,
    PH_POST,
    PH_OUT
  } phase_e;

  typedef enum logic [1:0] {
    BF_MUL,
    BF_GS,
    BF_CT
  } bf_mode_e;

  // Modular exponentiation by square-and-multiply, used only on constants.
  function automatic int unsigned powmod(int unsigned base, int unsigned ex, int unsigned m);
    longint unsigned r;
    longint unsigned x;
    r = 1;
    x = longint'(base % m);
    for (int i = 0; i < 32; i++) begin
      if (ex[i]) r = (r * x) % longint'(m);
      x = (x * x) % longint'(m);
    end
    return r[31:0];
  endfunction

  // Low index of butterfly j in a stage whose pair distance is 2**sh.
  function automatic int lo_idx(int j, int sh);
    return ((j >> sh) << (sh + 1)) + (j & ((1 << sh) - 1));
  endfunction

  // Twiddle exponent of butterfly j: position inside its group, scaled.
  function automatic int tw_exp(int j, int sh, int scale);
    return (j & ((1 << sh) - 1)) << scale;
  endfunction

endpackage

// File: rtl/ntt_rst_sync.sv
module ntt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/ntt_bfly.sv
module ntt_bfly
  import ntt_pkg::*;
#(
  parameter int P = 17,
  parameter int W = 5
) (
  input  bf_mode_e       mode,
  input  logic [W-1:0]   u,
  input  logic [W-1:0]   v,
  input  logic [W-1:0]   w,
  output logic [W-1:0]   o0,
  output logic [W-1:0]   o1
);

  localparam logic [W:0]     P_X  = (W+1)'(P);
  localparam logic [2*W-1:0] P_2W = (2*W)'(P);

  function automatic logic [W-1:0] add_m(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= P_X) s = s - P_X;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] sub_m(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + P_X - {1'b0, b};
    return s[W-1:0];
  endfunction

  logic [W-1:0]   diff;
  logic [W-1:0]   mul_x;
  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_r;
  logic [W-1:0]   mres;

  // One multiplier per unit; its first operand is steered by the mode.
  always_comb begin
    diff = sub_m(u, v);
    case (mode)
      BF_GS:   mul_x = diff;
      BF_CT:   mul_x = v;
      default: mul_x = u;
    endcase
    prod   = {{W{1'b0}}, mul_x} * {{W{1'b0}}, w};
    prod_r = prod % P_2W;
    mres   = prod_r[W-1:0];
  end

  always_comb begin
    case (mode)
      BF_GS: begin
        o0 = add_m(u, v);
        o1 = mres;
      end
      BF_CT: begin
        o0 = add_m(u, mres);
        o1 = sub_m(u, mres);
      end
      default: begin
        o0 = mres;
        o1 = v;
      end
    endcase
  end

endmodule

// File: rtl/ntt_seq.sv
module ntt_seq
  import ntt_pkg::*;
#(
  parameter int N   = 8,
  parameter int P   = 17,
  parameter int PSI = 3,
  parameter int W   = 5,
  parameter int AW  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 out_valid,
  output logic [AW-1:0]        out_idx,
  output logic [1:0]           op_bank,
  output logic [1:0][AW-1:0]   op_i0,
  output logic [1:0][AW-1:0]   op_i1,
  output logic [1:0][W-1:0]    op_w,
  output logic [1:0][1:0]      op_mode,
  output logic [1:0]           op_we0,
  output logic [1:0]           op_we1,
  output logic [1:0]           op_wmem
);

  localparam int LOGN = $clog2(N);
  localparam int unsigned OMEGA     = powmod(PSI, 2, P);
  localparam int unsigned OMEGA_INV = powmod(OMEGA, P - 2, P);
  localparam int unsigned PSI_INV   = powmod(PSI, P - 2, P);
  localparam int unsigned N_INV     = powmod(N, P - 2, P);

  localparam logic [AW-1:0] LAST_N    = AW'(N - 1);
  localparam logic [AW-1:0] LAST_HALF = AW'(N / 2 - 1);
  localparam logic [AW-1:0] LAST_QTR  = AW'(N / 4 - 1);
  localparam logic [AW-1:0] LAST_STG  = AW'(LOGN - 1);

  // Constant twiddle tables, computed at elaboration.
  logic [W-1:0] tw_om   [N];
  logic [W-1:0] tw_omi  [N];
  logic [W-1:0] tw_psi  [N];
  logic [W-1:0] tw_post [N];

  for (genvar k = 0; k < N; k++) begin : g_tw
    assign tw_om[k]   = W'(powmod(OMEGA, k, P));
    assign tw_omi[k]  = W'(powmod(OMEGA_INV, k, P));
    assign tw_psi[k]  = W'(powmod(PSI, k, P));
    assign tw_post[k] = W'((powmod(PSI_INV, k, P) * N_INV) % P);
  end

  phase_e        ph_q, ph_n;
  logic [AW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] stg_q, stg_n;
  logic          done_q, done_n;
  logic          adv;

  // Next-state logic.
  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    stg_n  = stg_q;
    done_n = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_n  = PH_PRE;
          cnt_n = '0;
          stg_n = '0;
        end
      end
      PH_PRE: begin
        if (cnt_q == LAST_N) begin
          ph_n  = PH_FWD;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_FWD: begin
        if (cnt_q == LAST_HALF) begin
          cnt_n = '0;
          if (stg_q == LAST_STG) begin
            ph_n  = PH_PMUL;
            stg_n = '0;
          end else begin
            stg_n = stg_q + 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_PMUL: begin
        if (cnt_q == LAST_HALF) begin
          ph_n  = PH_INV;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_INV: begin
        if (cnt_q == LAST_QTR) begin
          cnt_n = '0;
          if (stg_q == LAST_STG) begin
            ph_n  = PH_POST;
            stg_n = '0;
          end else begin
            stg_n = stg_q + 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_POST: begin
        if (cnt_q == LAST_HALF) begin
          ph_n  = PH_OUT;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_OUT: begin
        if (cnt_q == LAST_N) begin
          ph_n   = PH_IDLE;
          cnt_n  = '0;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  assign adv = (ph_q != PH_IDLE) || start;

  // State registers with explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      stg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
      if (adv) begin
        ph_q  <= ph_n;
        cnt_q <= cnt_n;
        stg_q <= stg_n;
      end
    end
  end

  // Per-unit operation decode.
  int sh_v;
  int j_v;
  int lo_v;

  always_comb begin
    op_bank = '0;
    op_i0   = '0;
    op_i1   = '0;
    op_w    = '0;
    op_mode = '0;
    op_we0  = '0;
    op_we1  = '0;
    op_wmem = '0;
    sh_v    = 0;
    j_v     = 0;
    lo_v    = 0;
    for (int u = 0; u < 2; u++) begin
      case (ph_q)
        PH_PRE: begin
          op_bank[u] = u[0];
          op_i0[u]   = cnt_q;
          op_i1[u]   = cnt_q;
          op_w[u]    = tw_psi[cnt_q];
          op_mode[u] = BF_MUL;
          op_we0[u]  = 1'b1;
        end
        PH_FWD: begin
          sh_v       = LOGN - 1 - int'(stg_q);
          j_v        = int'(cnt_q);
          lo_v       = lo_idx(j_v, sh_v);
          op_bank[u] = u[0];
          op_i0[u]   = AW'(lo_v);
          op_i1[u]   = AW'(lo_v + (1 << sh_v));
          op_w[u]    = tw_om[AW'(tw_exp(j_v, sh_v, int'(stg_q)))];
          op_mode[u] = BF_GS;
          op_we0[u]  = 1'b1;
          op_we1[u]  = 1'b1;
        end
        PH_PMUL: begin
          j_v        = 2 * int'(cnt_q) + u;
          op_i0[u]   = AW'(j_v);
          op_i1[u]   = AW'(j_v);
          op_mode[u] = BF_MUL;
          op_wmem[u] = 1'b1;
          op_we0[u]  = 1'b1;
        end
        PH_INV: begin
          sh_v       = int'(stg_q);
          j_v        = 2 * int'(cnt_q) + u;
          lo_v       = lo_idx(j_v, sh_v);
          op_i0[u]   = AW'(lo_v);
          op_i1[u]   = AW'(lo_v + (1 << sh_v));
          op_w[u]    = tw_omi[AW'(tw_exp(j_v, sh_v, LOGN - 1 - sh_v))];
          op_mode[u] = BF_CT;
          op_we0[u]  = 1'b1;
          op_we1[u]  = 1'b1;
        end
        PH_POST: begin
          j_v        = 2 * int'(cnt_q) + u;
          op_i0[u]   = AW'(j_v);
          op_i1[u]   = AW'(j_v);
          op_w[u]    = tw_post[AW'(j_v)];
          op_mode[u] = BF_MUL;
          op_we0[u]  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign out_valid = (ph_q == PH_OUT);
  assign out_idx   = cnt_q;
  assign done      = done_q;

  // R4: output indices advance by one per cycle while the stream runs.
  a_r4_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != LAST_N) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  // R4: the stream always opens at index zero.
  a_r4_idx_opens_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == '0));

  // R3: an idle start launches the engine on the next cycle.
  a_r3_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

endmodule

// File: rtl/ntt_negamul.sv
module ntt_negamul
  import ntt_pkg::*;
#(
  parameter int N   = 8,
  parameter int P   = 17,
  parameter int PSI = 3,
  localparam int W  = $clog2(P),
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_we,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  output logic          busy,
  output logic          done,
  output logic          out_valid,
  output logic [AW-1:0] out_idx,
  output logic [W-1:0]  out_data
);

  localparam logic [W-1:0]  P_LIM  = W'(P);
  localparam logic [AW-1:0] IDX_LAST = AW'(N - 1);

  logic srst_n;

  ntt_rst_sync rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  logic [1:0]          op_bank;
  logic [1:0][AW-1:0]  op_i0;
  logic [1:0][AW-1:0]  op_i1;
  logic [1:0][W-1:0]   op_w;
  logic [1:0][1:0]     op_mode;
  logic [1:0]          op_we0;
  logic [1:0]          op_we1;
  logic [1:0]          op_wmem;

  ntt_seq #(
    .N   (N),
    .P   (P),
    .PSI (PSI),
    .W   (W),
    .AW  (AW)
  ) seq_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .op_bank   (op_bank),
    .op_i0     (op_i0),
    .op_i1     (op_i1),
    .op_w      (op_w),
    .op_mode   (op_mode),
    .op_we0    (op_we0),
    .op_we1    (op_we1),
    .op_wmem   (op_wmem)
  );

  // Coefficient stores: bank a also holds the spectrum product and result.
  logic [W-1:0] mem_a   [N];
  logic [W-1:0] mem_b   [N];
  logic [W-1:0] mem_a_n [N];
  logic [W-1:0] mem_b_n [N];

  logic [1:0][W-1:0] res0;
  logic [1:0][W-1:0] res1;

  for (genvar g = 0; g < 2; g++) begin : g_unit
    logic [W-1:0] u_in;
    logic [W-1:0] v_in;
    logic [W-1:0] w_in;

    assign u_in = op_bank[g] ? mem_b[op_i0[g]] : mem_a[op_i0[g]];
    assign v_in = op_bank[g] ? mem_b[op_i1[g]] : mem_a[op_i1[g]];
    assign w_in = op_wmem[g] ? mem_b[op_i0[g]] : op_w[g];

    ntt_bfly #(
      .P (P),
      .W (W)
    ) bfly_i (
      .mode (bf_mode_e'(op_mode[g])),
      .u    (u_in),
      .v    (v_in),
      .w    (w_in),
      .o0   (res0[g]),
      .o1   (res1[g])
    );

    // R1: every value a unit writes back is a reduced residue.
    a_r1_unit_range: assert property (@(posedge clk) disable iff (!srst_n)
      (op_we0[g] |-> res0[g] < P_LIM) and (op_we1[g] |-> res1[g] < P_LIM));
  end

  logic load_ok;
  logic mem_en;

  assign load_ok = ld_we && !busy;
  assign mem_en  = load_ok || (|op_we0) || (|op_we1);

  always_comb begin
    mem_a_n = mem_a;
    mem_b_n = mem_b;
    if (load_ok) begin
      if (ld_sel) mem_b_n[ld_addr] = ld_data;
      else        mem_a_n[ld_addr] = ld_data;
    end
    for (int u = 0; u < 2; u++) begin
      if (op_we0[u]) begin
        if (op_bank[u]) mem_b_n[op_i0[u]] = res0[u];
        else            mem_a_n[op_i0[u]] = res0[u];
      end
      if (op_we1[u]) begin
        if (op_bank[u]) mem_b_n[op_i1[u]] = res1[u];
        else            mem_a_n[op_i1[u]] = res1[u];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < N; i++) begin
        mem_a[i] <= '0;
        mem_b[i] <= '0;
      end
    end else if (mem_en) begin
      mem_a <= mem_a_n;
      mem_b <= mem_b_n;
    end
  end

  assign out_data = mem_a[out_idx];

  // R1: streamed coefficients are reduced residues.
  a_r1_out_range: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> (out_data < P_LIM));

  // R5: the completion pulse lasts a single cycle.
  a_r5_done_single: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);

  // R5: the completion pulse follows the last streamed coefficient.
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> ($past(out_valid) && $past(out_idx) == IDX_LAST));

  // R6: once launched, the engine stays busy until its output stream.
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !out_valid) |=> busy);

  // R4: results are only streamed during a run.
  a_r4_valid_in_run: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> busy);

endmodule

// File: tb/ntt_negamul_tb_top.sv
module ntt_negamul_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int PM = 17;
  localparam int LAT = 35;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       ld_we;
  logic       ld_sel;
  logic [2:0] ld_addr;
  logic [4:0] ld_data;
  logic       busy;
  logic       done;
  logic       out_valid;
  logic [2:0] out_idx;
  logic [4:0] out_data;

  int checks;
  int errors;
  bit finished;

  int opa [NC];
  int opb [NC];
  int expc [NC];

  ntt_negamul dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ld_we     (ld_we),
    .ld_sel    (ld_sel),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  // Schoolbook product reduced by x^8 + 1.
  task automatic ref_product();
    int acc [NC];
    for (int k = 0; k < NC; k++) acc[k] = 0;
    for (int i = 0; i < NC; i++) begin
      for (int j = 0; j < NC; j++) begin
        if (i + j < NC) acc[i + j] += opa[i] * opb[j];
        else            acc[i + j - NC] -= opa[i] * opb[j];
      end
    end
    for (int k = 0; k < NC; k++) expc[k] = ((acc[k] % PM) + PM) % PM;
  endtask

  task automatic load_ops();
    for (int i = 0; i < NC; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_sel = 1'b0; ld_addr = 3'(i); ld_data = 5'(opa[i]);
    end
    for (int i = 0; i < NC; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 3'(i); ld_data = 5'(opb[i]);
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // Launch, count edges to the first output, compare the stream.
  task automatic run_check(string req, bit poke_start, bit poke_load, bit chain);
    int lat;
    ref_product();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 1;
    chk("R3", "busy after start", int'(busy), 1);
    while (!out_valid && lat < 100) begin
      start = (poke_start && lat == 10);
      if (poke_load && lat == 12) begin
        ld_we = 1'b1; ld_sel = 1'b0; ld_addr = 3'd3; ld_data = 5'd5;
      end else if (poke_load && lat == 20) begin
        ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 3'd0; ld_data = 5'd9;
      end else begin
        ld_we = 1'b0;
      end
      @(posedge clk); #1;
      lat++;
    end
    start = 1'b0;
    ld_we = 1'b0;
    chk(poke_start ? "R6" : "R4", "latency to first output", lat, LAT);
    for (int k = 0; k < NC; k++) begin
      chk("R4", "out_valid in stream", int'(out_valid), 1);
      chk("R4", "out_idx", int'(out_idx), k);
      chk(poke_load ? "R7" : req, $sformatf("coef %0d", k), int'(out_data), expc[k]);
      chk("R5", "done low during stream", int'(done), 0);
      @(posedge clk); #1;
    end
    chk("R5", "done after last", int'(done), 1);
    chk("R4", "out_valid after stream", int'(out_valid), 0);
    if (chain) start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk("R5", "done single cycle", int'(done), 0);
    if (chain) begin
      chk("R10", "busy after start in done cycle", int'(busy), 1);
      lat = 1;
      while (!out_valid && lat < 100) begin
        @(posedge clk); #1;
        lat++;
      end
      chk("R10", "chained latency", lat, LAT);
      while (busy) begin
        @(posedge clk); #1;
      end
      chk("R10", "chained done", int'(done), 1);
    end
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; ld_we = 1'b0; ld_sel = 1'b0;
    ld_addr = '0; ld_data = '0;
    repeat (4) @(posedge clk);
    #1;
    chk("R9", "busy in reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R9", "busy after reset", int'(busy), 0);
    chk("R9", "done after reset", int'(done), 0);
    chk("R9", "out_valid after reset", int'(out_valid), 0);

    // R2: unit polynomial in a, arbitrary b: product must be b.
    for (int i = 0; i < NC; i++) begin
      opa[i] = (i == 0) ? 1 : 0;
      opb[i] = (3 * i + 2) % PM;
    end
    load_ops();
    run_check("R2", 1'b0, 1'b0, 1'b0);

    // R8 / R1: all monomial pairs, exercising every wrap position.
    for (int i = 0; i < NC; i++) begin
      for (int j = 0; j < NC; j++) begin
        for (int k = 0; k < NC; k++) begin
          opa[k] = (k == i) ? (i + 1) : 0;
          opb[k] = (k == j) ? ((j + 2) % PM) : 0;
        end
        load_ops();
        run_check((i + j >= NC) ? "R8" : "R1", 1'b0, 1'b0, 1'b0);
      end
    end

    // R1: extreme values.
    for (int i = 0; i < NC; i++) begin
      opa[i] = PM - 1;
      opb[i] = PM - 1;
    end
    load_ops();
    run_check("R1", 1'b0, 1'b0, 1'b0);

    // R1: random operands.
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < NC; i++) begin
        opa[i] = int'($urandom % PM);
        opb[i] = int'($urandom % PM);
      end
      load_ops();
      run_check("R1", 1'b0, 1'b0, 1'b0);
    end

    // R6: start pulsed mid-run.
    for (int i = 0; i < NC; i++) begin
      opa[i] = int'($urandom % PM);
      opb[i] = int'($urandom % PM);
    end
    load_ops();
    run_check("R6", 1'b1, 1'b0, 1'b0);

    // R7: writes strobed mid-run; R10: restart in the done cycle.
    for (int i = 0; i < NC; i++) begin
      opa[i] = int'($urandom % PM);
      opb[i] = int'($urandom % PM);
    end
    load_ops();
    run_check("R7", 1'b0, 1'b1, 1'b1);

    // Fresh run after the chained one still correct.
    for (int i = 0; i < NC; i++) begin
      opa[i] = (5 * i + 1) % PM;
      opb[i] = (7 * i + 4) % PM;
    end
    load_ops();
    run_check("R1", 1'b0, 1'b0, 1'b0);

    report();
  end

endmodule